// File: doc/BRIEF.md
# Lockstep Update Comparator with Checkpoint Recovery

This block sits between two identical copies of a processor's execution logic and the master copy of architected state. Each copy presents the same register update (an 8-bit register address and 64 bits of data) in the same cycle. The block compares the two and keeps matching updates in an in-order buffer. When the instruction that produced them is reported complete, it writes them one per cycle into an ECC-protected checkpoint array of 256 registers. Every write is also sent out on a shared address/data broadcast port, so that the local register copies held elsewhere in the chip follow the master copy.

A disagreement between the copies, or an error reported from elsewhere, stops all further commits. Buffered updates of the instruction still in flight are thrown away. Updates of instructions that had already completed are allowed to finish writing. A recovery sequencer then runs three phases in a fixed order, each with its own request/done handshake: drain completed stores, purge caches and translation buffers, and reset the pipelines. It then reads every checkpoint entry from address 0 up to 255, corrects any single-bit error, writes the entry back, and broadcasts it. When the walk finishes, an internal interrupt is left pending and the cause is held in a log until it is acknowledged. A double-bit error found during the walk is uncorrectable: it raises a sticky fatal output and halts the sequencer.

Top module: `lockstep_ckpt_unit`

## Requirements
- R1: While not recovering, a cycle in which the two copies disagree starts recovery: `recov_busy` is high from the next cycle and `err_cause` bit 0 is set. Disagreement means the valid flags differ, or both are valid and the addresses or data differ.
- R2: While not recovering, `hw_err` high starts recovery: `recov_busy` is high from the next cycle and `err_cause` bit 1 is set.
- R3: Matching updates are buffered and are not broadcast until `instr_done` is seen (an update in the same cycle as `instr_done` belongs to that instruction). Committed updates are then written to the checkpoint and broadcast in arrival order, one per cycle, on `bc_vld`/`bc_addr`/`bc_data`.
- R4: Updates of an instruction that has not completed when an error is seen are discarded. This includes an `instr_done` in the same cycle as the error, which is ignored. Such updates are never broadcast and never reach the checkpoint.
- R5: Updates of instructions that completed before the error cycle are still committed and broadcast before the recovery handshakes begin.
- R6: Recovery raises `drain_req`, then `purge_req`, then `prst_req`. Each request is held until its done input is seen high, and at most one request is high at a time.
- R7: After the pipeline reset, all 256 checkpoint entries are broadcast in ascending address order with their stored data. `recov_busy` then falls.
- R8: While `recov_busy` is high, update inputs, `instr_done` and `hw_err` have no effect on the checkpoint contents.
- R9: A single-bit checkpoint error is corrected on the broadcast during the walk, and the corrected word is written back to the array.
- R10: A double-bit error found during the walk sets `fatal`. The walk stops before that entry is broadcast. `fatal` and `recov_busy` stay high until reset.
- R11: `irq_pend` rises in the cycle `recov_busy` falls. `irq_pend` and `err_cause` hold until `irq_ack`, which clears both.
- R12: After reset all checkpoint entries hold zero, and `recov_busy`, `irq_pend`, `fatal`, `bc_vld` and all requests are low.
- R13: `inj_vld` XORs `inj_flip` into the stored 72-bit codeword at `inj_addr`. The codeword layout is: bit 0 is overall parity; bits 1, 2, 4, 8, 16, 32 and 64 are Hamming check bits; data bits 0 to 63 fill the remaining positions 3 to 71 in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Copy A update valid |
| a_addr | input | 8 | Copy A register address |
| a_data | input | 64 | Copy A register data |
| b_vld | input | 1 | Copy B update valid |
| b_addr | input | 8 | Copy B register address |
| b_data | input | 64 | Copy B register data |
| instr_done | input | 1 | Current instruction completed |
| hw_err | input | 1 | Error detected elsewhere in the hardware |
| inj_vld | input | 1 | Apply an error-injection mask |
| inj_addr | input | 8 | Entry to inject into |
| inj_flip | input | 72 | Codeword bits to invert |
| bc_vld | output | 1 | Broadcast valid |
| bc_addr | output | 8 | Broadcast register address |
| bc_data | output | 64 | Broadcast register data |
| drain_req | output | 1 | Request to drain completed stores |
| drain_done | input | 1 | Store drain finished |
| purge_req | output | 1 | Request to purge cache, directory and translation buffers |
| purge_done | input | 1 | Purge finished |
| prst_req | output | 1 | Request to reset pipeline controls |
| prst_done | input | 1 | Pipeline reset finished |
| recov_busy | output | 1 | Recovery in progress (or halted) |
| irq_pend | output | 1 | Internal interrupt pending after recovery |
| irq_ack | input | 1 | Clears `irq_pend` and `err_cause` |
| err_cause | output | 2 | Logged cause: bit 0 miscompare, bit 1 external error |
| fatal | output | 1 | Uncorrectable checkpoint error during refresh |

## Verification
Two events can meet in one cycle: the end of an instruction and an error. The bench provokes this by driving a matching update together with `instr_done` and `hw_err` in the same cycle. A scoreboard then expects none of that instruction's updates on the broadcast port, and expects the refresh walk to show the old register values. The opposite edge is covered by an instruction that completes one cycle before the error, while its updates are still leaving the buffer. For that case the scoreboard requires both updates to be broadcast before the refresh, and the refreshed values to include them.

// File: rtl/lockstep_ckpt_unit.sv
module lockstep_ckpt_unit #(
  parameter int AW = 8,
  parameter int DW = 64,
  parameter int BUF_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_vld,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic          b_vld,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  input  logic          instr_done,
  input  logic          hw_err,
  input  logic          inj_vld,
  input  logic [AW-1:0] inj_addr,
  input  logic [DW+7:0] inj_flip,
  output logic          bc_vld,
  output logic [AW-1:0] bc_addr,
  output logic [DW-1:0] bc_data,
  output logic          drain_req,
  input  logic          drain_done,
  output logic          purge_req,
  input  logic          purge_done,
  output logic          prst_req,
  input  logic          prst_done,
  output logic          recov_busy,
  output logic          irq_pend,
  input  logic          irq_ack,
  output logic [1:0]    err_cause,
  output logic          fatal
);
  function automatic int calc_pb(input int dw);
    int r;
    r = 0;
    for (int k = 1; k < 16; k++)
      if (r == 0 && (1 << k) >= dw + k + 1) r = k;
    return r;
  endfunction

  localparam int PB   = calc_pb(DW);
  localparam int CW   = DW + PB + 1;
  localparam int NENT = 1 << AW;
  localparam int BPW  = $clog2(BUF_DEPTH);

  typedef enum logic [2:0] {S_RUN, S_FLUSH, S_DRAIN, S_PURGE, S_PRST, S_REFR, S_HALT} st_t;

  function automatic logic [CW-1:0] ecc_enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic x;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    for (int k = 0; k < PB; k++) begin
      x = 1'b0;
      for (int p = 1; p < CW; p++)
        if (((p >> k) & 1) == 1 && (p & (p - 1)) != 0) x = x ^ c[p];
      c[1 << k] = x;
    end
    c[0] = ^c;
    return c;
  endfunction

  function automatic logic [PB-1:0] ecc_syn(input logic [CW-1:0] c);
    logic [PB-1:0] s;
    s = '0;
    for (int p = 1; p < CW; p++)
      if (c[p]) s = s ^ PB'(p);
    return s;
  endfunction

  function automatic logic [DW-1:0] ecc_data(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p];
        j++;
      end
    return d;
  endfunction

  logic [CW-1:0] mem [NENT];
  logic [AW-1:0] fa [BUF_DEPTH];
  logic [DW-1:0] fd [BUF_DEPTH];
  logic [BPW:0]  wp, rp, lim;
  logic [AW-1:0] ra;
  st_t           st;

  logic miscmp, err_ev, acc, drn;
  logic [CW-1:0] rd_cw, fixed_cw;
  logic [PB-1:0] rsyn;
  logic          rov, r_dbl;
  logic [DW-1:0] r_data;

  assign miscmp = (a_vld != b_vld) || (a_vld && (a_addr != b_addr || a_data != b_data));
  assign err_ev = (st == S_RUN) && (miscmp || hw_err);
  assign acc    = (st == S_RUN) && !err_ev && a_vld;
  assign drn    = (st == S_RUN || st == S_FLUSH) && (rp != lim);

  assign rd_cw    = mem[ra];
  assign rsyn     = ecc_syn(rd_cw);
  assign rov      = ^rd_cw;
  assign r_dbl    = (rsyn != '0 && !rov) || (rov && int'(rsyn) >= CW);
  assign fixed_cw = rd_cw ^ (rov ? (CW'(1) << rsyn) : '0);
  assign r_data   = ecc_data(fixed_cw);

  assign recov_busy = (st != S_RUN);
  assign drain_req  = (st == S_DRAIN);
  assign purge_req  = (st == S_PURGE);
  assign prst_req   = (st == S_PRST);

  always_ff @(posedge clk)
    if (acc) begin
      fa[wp[BPW-1:0]] <= a_addr;
      fd[wp[BPW-1:0]] <= a_data;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) mem[i] <= '0;
    end else begin
      if (inj_vld) mem[inj_addr] <= mem[inj_addr] ^ inj_flip;
      if (drn) mem[fa[rp[BPW-1:0]]] <= ecc_enc(fd[rp[BPW-1:0]]);
      if (st == S_REFR && !r_dbl) mem[ra] <= ecc_enc(r_data);
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      st        <= S_RUN;
      wp        <= '0;
      rp        <= '0;
      lim       <= '0;
      ra        <= '0;
      bc_vld    <= 1'b0;
      bc_addr   <= '0;
      bc_data   <= '0;
      irq_pend  <= 1'b0;
      err_cause <= 2'b00;
      fatal     <= 1'b0;
    end else begin
      bc_vld <= 1'b0;
      if (acc) wp <= wp + 1'b1;
      if (st == S_RUN && instr_done && !err_ev) lim <= wp + (BPW+1)'(acc);
      if (drn) begin
        rp      <= rp + 1'b1;
        bc_vld  <= 1'b1;
        bc_addr <= fa[rp[BPW-1:0]];
        bc_data <= fd[rp[BPW-1:0]];
      end
      if (irq_ack) begin
        irq_pend  <= 1'b0;
        err_cause <= 2'b00;
      end
      case (st)
        S_RUN:
          if (err_ev) begin
            err_cause <= err_cause | {hw_err, miscmp};
            wp        <= lim;
            st        <= S_FLUSH;
          end
        S_FLUSH: if (rp == lim) st <= S_DRAIN;
        S_DRAIN: if (drain_done) st <= S_PURGE;
        S_PURGE: if (purge_done) st <= S_PRST;
        S_PRST:
          if (prst_done) begin
            ra <= '0;
            st <= S_REFR;
          end
        S_REFR:
          if (r_dbl) begin
            fatal <= 1'b1;
            st    <= S_HALT;
          end else begin
            bc_vld  <= 1'b1;
            bc_addr <= ra;
            bc_data <= r_data;
            ra      <= ra + 1'b1;
            if (ra == AW'(NENT - 1)) begin
              st       <= S_RUN;
              irq_pend <= 1'b1;
            end
          end
        default: st <= S_HALT;
      endcase
    end
endmodule

// File: rtl/lockstep_ckpt_props.sv
module lockstep_ckpt_props (
  input logic clk,
  input logic rst_n,
  input logic a_vld,
  input logic b_vld,
  input logic hw_err,
  input logic drain_req,
  input logic drain_done,
  input logic purge_req,
  input logic purge_done,
  input logic prst_req,
  input logic recov_busy,
  input logic irq_pend,
  input logic fatal
);
  a_r1_miscmp_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!recov_busy && (a_vld != b_vld)) |=> recov_busy);

  a_r2_err_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!recov_busy && hw_err) |=> recov_busy);

  a_r6_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drain_req, purge_req, prst_req}));

  a_r6_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && !drain_done) |=> drain_req);

  a_r6_purge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_req && !purge_done) |=> purge_req);

  a_r6_purge_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(purge_req) |-> $past(drain_req));

  a_r10_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> (fatal && recov_busy));

  a_r11_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $fell(recov_busy));
endmodule

bind lockstep_ckpt_unit lockstep_ckpt_props u_props (
  .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .b_vld(b_vld), .hw_err(hw_err),
  .drain_req(drain_req), .drain_done(drain_done), .purge_req(purge_req),
  .purge_done(purge_done), .prst_req(prst_req), .recov_busy(recov_busy),
  .irq_pend(irq_pend), .fatal(fatal)
);

// File: tb/lockstep_ckpt_unit_tb.sv
module lockstep_ckpt_unit_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        a_vld, b_vld, instr_done, hw_err, inj_vld, irq_ack;
  logic [7:0]  a_addr, b_addr, inj_addr;
  logic [63:0] a_data, b_data;
  logic [71:0] inj_flip;
  logic        bc_vld, drain_req, purge_req, prst_req, recov_busy, irq_pend, fatal;
  logic [7:0]  bc_addr;
  logic [63:0] bc_data;
  logic [1:0]  err_cause;
  logic [2:0]  donev;
  logic [2:0]  reqv;

  assign reqv = {prst_req, purge_req, drain_req};

  lockstep_ckpt_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_addr(a_addr), .a_data(a_data),
    .b_vld(b_vld), .b_addr(b_addr), .b_data(b_data),
    .instr_done(instr_done), .hw_err(hw_err),
    .inj_vld(inj_vld), .inj_addr(inj_addr), .inj_flip(inj_flip),
    .bc_vld(bc_vld), .bc_addr(bc_addr), .bc_data(bc_data),
    .drain_req(drain_req), .drain_done(donev[0]),
    .purge_req(purge_req), .purge_done(donev[1]),
    .prst_req(prst_req), .prst_done(donev[2]),
    .recov_busy(recov_busy), .irq_pend(irq_pend), .irq_ack(irq_ack),
    .err_cause(err_cause), .fatal(fatal)
  );

  typedef struct packed { logic [7:0] a; logic [63:0] d; } item_t;
  item_t       exp_q[$];
  item_t       pend_q[$];
  item_t       mon_e;
  logic [63:0] model [256];
  int          total = 0;
  int          bad = 0;
  int          refr_stop = 256;
  bit          finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic push_refresh();
    for (int i = 0; i < refr_stop; i++) exp_q.push_back('{a: 8'(i), d: model[i]});
  endtask

  task automatic cyc(input bit av, input bit bv, input logic [7:0] aa, input logic [7:0] ba,
                     input logic [63:0] ad, input logic [63:0] bd, input bit fin, input bit ext);
    @(posedge clk); #1;
    a_vld = av; b_vld = bv; a_addr = aa; b_addr = ba; a_data = ad; b_data = bd;
    instr_done = fin; hw_err = ext;
    if (!recov_busy) begin
      if ((av != bv) || (av && (aa != ba || ad != bd)) || ext) begin
        pend_q.delete();
        push_refresh();
      end else begin
        if (av) pend_q.push_back('{a: aa, d: ad});
        if (fin) begin
          foreach (pend_q[i]) begin
            exp_q.push_back(pend_q[i]);
            model[pend_q[i].a] = pend_q[i].d;
          end
          pend_q.delete();
        end
      end
    end
  endtask

  task automatic upd(input logic [7:0] ad, input logic [63:0] d, input bit fin);
    cyc(1, 1, ad, ad, d, d, fin, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      a_vld = 0; b_vld = 0; instr_done = 0; hw_err = 0; inj_vld = 0; irq_ack = 0;
    end
  endtask

  task automatic inject(input logic [7:0] ad, input logic [71:0] m);
    @(posedge clk); #1;
    inj_vld = 1; inj_addr = ad; inj_flip = m;
    idle(1);
  endtask

  task automatic wait_settle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!recov_busy && exp_q.size() == 0) break;
    end
  endtask

  task automatic ack_irq(input string req, input logic [1:0] cause);
    @(negedge clk);
    chk(irq_pend == 1'b1, {req, " R11 irq pending after recovery"}, 64'(irq_pend), 1);
    chk(err_cause == cause, {req, " R11 cause held"}, 64'(err_cause), 64'(cause));
    @(posedge clk); #1; irq_ack = 1;
    idle(1);
    @(negedge clk);
    chk(irq_pend == 1'b0 && err_cause == 2'b00, "R11 ack clears", {62'h0, err_cause}, 0);
  endtask

  always @(negedge clk)
    if (rst_n && bc_vld) begin
      if (exp_q.size() == 0) chk(0, "R3/R7 unexpected broadcast", 64'(bc_addr), 0);
      else begin
        mon_e = exp_q.pop_front();
        chk(bc_addr == mon_e.a, "R7 broadcast address", 64'(bc_addr), 64'(mon_e.a));
        chk(bc_data == mon_e.d, "R3/R9 broadcast data", bc_data, mon_e.d);
      end
    end

  initial begin
    int nxt;
    int idx;
    donev = 3'b000;
    nxt = 0;
    forever begin
      @(negedge clk);
      if (rst_n && |reqv) begin
        idx = reqv[0] ? 0 : (reqv[1] ? 1 : 2);
        chk($onehot(reqv), "R6 single request", 64'(reqv), 0);
        chk(idx == nxt, "R6 phase order", 64'(idx), 64'(nxt));
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk(reqv[idx], "R6 request held", 64'(reqv), 64'(1 << idx));
        end
        donev[idx] = 1'b1;
        @(negedge clk);
        donev[idx] = 1'b0;
        nxt = (nxt + 1) % 3;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 0);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 64'h0;
    rst_n = 0; a_vld = 0; b_vld = 0; instr_done = 0; hw_err = 0; inj_vld = 0; irq_ack = 0;
    a_addr = 0; b_addr = 0; a_data = 0; b_data = 0; inj_addr = 0; inj_flip = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!recov_busy && !irq_pend && !fatal, "R12 reset flags", {61'h0, recov_busy, irq_pend, fatal}, 0);
    chk(!bc_vld && reqv == 3'b000, "R12 reset outputs", {60'h0, bc_vld, reqv}, 0);

    // R3: buffered until done, then committed in order
    upd(8'd5, 64'h5555_0000_aaaa_0001, 0);
    upd(8'd10, 64'h1010_1010_0000_0001, 0);
    idle(4);
    chk(exp_q.size() == 3 - 1 - 2 + 0, "R3 nothing committed before done", 64'(exp_q.size()), 0);
    upd(8'd11, 64'hbeef_0000_0000_0011, 1);
    idle(1);
    upd(8'd10, 64'hc0de_0000_0000_0010, 0);
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle(1);
    wait_settle();

    // R2 + R4: pending update dropped on external error
    upd(8'd20, 64'hdead_0000_0000_0020, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    @(negedge clk);
    chk(recov_busy, "R2 busy after hw_err", 64'(recov_busy), 1);
    chk(err_cause == 2'b10, "R2 cause logged", 64'(err_cause), 2);
    wait_settle();
    ack_irq("R2", 2'b10);

    // R1 data miscompare, R8 updates during recovery ignored
    upd(8'd30, 64'h3030_0000_0000_0030, 0);
    cyc(1, 1, 8'd31, 8'd31, 64'h1, 64'h3, 0, 0);
    idle(1);
    @(negedge clk);
    chk(recov_busy, "R1 busy after data miscompare", 64'(recov_busy), 1);
    chk(err_cause == 2'b01, "R1 cause logged", 64'(err_cause), 1);
    upd(8'd40, 64'h4040_4040_4040_4040, 1);
    upd(8'd10, 64'hffff_ffff_ffff_ffff, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    wait_settle();
    ack_irq("R1", 2'b01);

    // R4: done in the same cycle as an error is ignored
    upd(8'd50, 64'h5050_0000_0000_0050, 0);
    cyc(1, 1, 8'd51, 8'd51, 64'h51, 64'h51, 1, 1);
    idle(1);
    wait_settle();
    ack_irq("R4", 2'b10);

    // R5: completed instruction still commits; R1 valid mismatch
    upd(8'd60, 64'h6060_0000_0000_0060, 0);
    upd(8'd61, 64'h6161_0000_0000_0061, 1);
    cyc(1, 0, 8'd62, 8'd0, 64'h62, 64'h0, 0, 0);
    idle(1);
    @(negedge clk);
    chk(recov_busy, "R1 busy after valid mismatch", 64'(recov_busy), 1);
    wait_settle();
    ack_irq("R5", 2'b01);

    // R9/R13: single-bit errors in data, overall parity and a check bit
    inject(8'd5, 72'(1) << 10);
    inject(8'd6, 72'(1));
    inject(8'd7, 72'(1) << 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    wait_settle();
    ack_irq("R9", 2'b10);
    // R9: corrected word was written back, so a second flip stays single
    inject(8'd5, 72'(1) << 20);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    wait_settle();
    chk(fatal == 1'b0, "R9 write-back prevents double error", 64'(fatal), 0);
    ack_irq("R9", 2'b10);

    // R10: double-bit error halts the walk
    inject(8'd9, (72'(1) << 3) | (72'(1) << 12));
    refr_stop = 9;
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (fatal) break;
    end
    idle(5);
    @(negedge clk);
    chk(fatal == 1'b1, "R10 fatal raised", 64'(fatal), 1);
    chk(recov_busy == 1'b1, "R10 stays busy", 64'(recov_busy), 1);
    chk(exp_q.size() == 0, "R10 walk stopped at bad entry", 64'(exp_q.size()), 0);
    chk(irq_pend == 1'b0, "R10 no interrupt on halt", 64'(irq_pend), 0);

    finished = 1;
    summary();
  end
endmodule